// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the three vector configuration instructions. It takes the 32-bit instruction word and the scalar operands, and decodes which form is present. It works out the largest legal vector length for the requested element width and register grouping. It then commits the new vector length and vector type to registered state, and it returns the granted length as the scalar result for the destination register in the same cycle.

Two forms take the requested length (AVL) from a scalar register. One of them takes the type immediate from the instruction, and the other takes it from a second scalar register. These two forms clip the requested length to the maximum. The third form takes a small unsigned AVL immediate from the source register field. It never clips. An immediate that the selected type cannot hold marks the configuration illegal, so that software errors stay visible.

The hardware register width VLEN, the widest element ELEN and the scalar width XLEN are parameters. Register storage, hazards and the vector datapath belong to other blocks.

Top module: `vcfg_unit`

## Requirements
- R1: An instruction is recognised only when bits 6:0 are 1010111 and bits 14:12 are 111. The form is then chosen from the top bits: bit 31 = 0 is the register-AVL form with the type immediate in bits 30:20, bits 31:30 = 11 is the immediate-AVL form with the type immediate in bits 29:20, and bits 31:25 = 1000000 is the register-type form with the type taken from rs2_val. Any other word gives cfg_hit = 0 and rd_wdata = 0.
- R2: The type value encodes the grouping in bits 2:0 (000=1, 001=2, 010=4, 011=8, 101=1/8, 110=1/4, 111=1/2), the element width in bits 5:3 as SEW = 8 << code, tail-agnostic in bit 6 and mask-agnostic in bit 7. A legal type is stored unchanged in vtype_o.
- R3: The type is illegal when the grouping code is 100, when the width code is 1xx or gives SEW > ELEN, when any type bit above bit 7 is set, or when VLMAX = VLEN*LMUL/SEW rounds down to zero.
- R4: An illegal configuration sets vill_o = 1 and forces vl_o = 0 and vtype_o = 0.
- R5: In the register forms, when the rs1 index (bits 19:15) is nonzero, the new vl is min(rs1_val, VLMAX).
- R6: In the register forms, when the rs1 index is zero and the rd index (bits 11:7) is nonzero, the new vl is VLMAX.
- R7: In the register forms, when both the rs1 and rd indices are zero, the new vl is min(current vl, VLMAX).
- R8: In the immediate-AVL form, the AVL is bits 19:15 zero-extended, and the value 00000 means 32. A fitting AVL becomes vl without change.
- R9: In the immediate-AVL form, an AVL greater than VLMAX sets vill_o, as in R4, instead of clipping.
- R10: While instr_valid and cfg_hit are high, rd_wdata carries the new vl in the same cycle, zero-extended to XLEN.
- R11: Reset gives vl_o = 0, vtype_o = 0 and vill_o = 1. State changes only on a clock edge where instr_valid and cfg_hit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of scalar source register rs1 |
| rs2_val | input | XLEN | Value of scalar source register rs2 (register-type form) |
| cfg_hit | output | 1 | Word is a recognised configuration instruction |
| rd_wdata | output | XLEN | New vl for the destination register |
| vl_o | output | $clog2(VLEN)+1 | Current vector length |
| vtype_o | output | 8 | Current vector type fields |
| vill_o | output | 1 | Current configuration is illegal |

## Verification
The bench covers each grouping factor, including the fractional ones, together with several element widths. This separates a wrong VLMAX exponent from a wrong clip. The register forms are driven with an AVL below, equal to and above VLMAX, and with the three index cases for rs1 and rd, so that clipping, the request for the maximum and keeping the current length can each be told apart. The immediate form is driven with zero, with a fitting value, with VLMAX plus one and with 31, which separates zero-means-32 and the setting of vill from clipping. Illegal types, unrecognised encodings and cycles without valid show whether state is forced or left alone.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam logic [6:0] OPC_VEC   = 7'b1010111;
    localparam logic [2:0] F3_CFG    = 3'b111;
    localparam logic [6:0] TOP_RVT   = 7'b1000000;
    localparam int         IMM_ZERO_AVL = 32;

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_RAVL,
        FORM_RVT,
        FORM_IAVL
    } cfg_form_e;

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs2_val,
    output cfg_form_e       form,
    output logic [XLEN-1:0] vtype_raw,
    output logic            src_idx_zero,
    output logic            dst_idx_zero,
    output logic [4:0]      uimm
);

    logic base_ok;

    always_comb begin
        base_ok      = (instr[6:0] == OPC_VEC) && (instr[14:12] == F3_CFG);
        src_idx_zero = (instr[19:15] == 5'd0);
        dst_idx_zero = (instr[11:7] == 5'd0);
        uimm         = instr[19:15];
        form         = FORM_NONE;
        vtype_raw    = '0;
        if (base_ok) begin
            if (!instr[31]) begin
                form      = FORM_RAVL;
                vtype_raw = XLEN'(instr[30:20]);
            end else if (instr[30]) begin
                form      = FORM_IAVL;
                vtype_raw = XLEN'(instr[29:20]);
            end else if (instr[31:25] == TOP_RVT) begin
                form      = FORM_RVT;
                vtype_raw = rs2_val;
            end
        end
    end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
    parameter int VLEN = 128,
    parameter int ELEN = 64,
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] vtype_raw,
    output logic            legal,
    output logic [$clog2(VLEN):0] vlmax
);

    localparam int LOG_VLEN = $clog2(VLEN);
    localparam int LOG_ELEN = $clog2(ELEN);
    localparam int VLW      = LOG_VLEN + 1;

    logic [2:0] lmul_code;
    logic [2:0] sew_code;
    int         lmul_log;
    int         sew_log;
    int         expo;

    always_comb begin
        lmul_code = vtype_raw[2:0];
        sew_code  = vtype_raw[5:3];
        lmul_log  = lmul_code[2] ? (int'(lmul_code) - 8) : int'(lmul_code);
        sew_log   = 3 + int'(sew_code);
        expo      = LOG_VLEN + lmul_log - sew_log;
        legal     = (lmul_code != 3'b100) && !sew_code[2] && (sew_log <= LOG_ELEN)
                    && !(|vtype_raw[XLEN-1:8]) && (expo >= 0);
        vlmax     = '0;
        if (legal) begin
            vlmax = VLW'(1) << expo;
        end
    end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int ELEN = 64,
    parameter int XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  instr_valid,
    input  logic [31:0]           instr,
    input  logic [XLEN-1:0]       rs1_val,
    input  logic [XLEN-1:0]       rs2_val,
    output logic                  cfg_hit,
    output logic [XLEN-1:0]       rd_wdata,
    output logic [$clog2(VLEN):0] vl_o,
    output logic [7:0]            vtype_o,
    output logic                  vill_o
);

    localparam int VLW = $clog2(VLEN) + 1;

    typedef struct packed {
        logic [VLW-1:0] vl;
        logic [7:0]     vtype;
        logic           vill;
    } cfg_state_t;

    cfg_form_e        form;
    logic [XLEN-1:0]  vtype_raw;
    logic             src_idx_zero;
    logic             dst_idx_zero;
    logic [4:0]       uimm;
    logic             type_legal;
    logic [VLW-1:0]   vlmax;

    cfg_state_t       state_d, state_q, cand;
    logic [XLEN-1:0]  avl;
    logic [XLEN-1:0]  vlmax_x;
    logic             imm_over;
    logic             commit;

    vcfg_decode #(.XLEN(XLEN)) dec_i (
        .instr        (instr),
        .rs2_val      (rs2_val),
        .form         (form),
        .vtype_raw    (vtype_raw),
        .src_idx_zero (src_idx_zero),
        .dst_idx_zero (dst_idx_zero),
        .uimm         (uimm)
    );

    vcfg_vlmax #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) vmx_i (
        .vtype_raw (vtype_raw),
        .legal     (type_legal),
        .vlmax     (vlmax)
    );

    always_comb begin
        cfg_hit  = (form != FORM_NONE);
        commit   = instr_valid && cfg_hit;
        vlmax_x  = XLEN'(vlmax);
        imm_over = 1'b0;
        avl      = '0;
        cand     = '{vl: '0, vtype: vtype_raw[7:0], vill: 1'b0};

        if (form == FORM_IAVL) begin
            avl      = (uimm == 5'd0) ? XLEN'(IMM_ZERO_AVL) : XLEN'(uimm);
            imm_over = (avl > vlmax_x);
            cand.vl  = VLW'(avl);
        end else begin
            if (!src_idx_zero) begin
                avl = rs1_val;
            end else if (!dst_idx_zero) begin
                avl = '1;
            end else begin
                avl = XLEN'(state_q.vl);
            end
            cand.vl = (avl > vlmax_x) ? vlmax : VLW'(avl);
        end

        if (!type_legal || imm_over) begin
            cand = '{vl: '0, vtype: '0, vill: 1'b1};
        end

        state_d  = commit ? cand : state_q;
        rd_wdata = commit ? XLEN'(cand.vl) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{vl: '0, vtype: '0, vill: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign vl_o    = state_q.vl;
    assign vtype_o = state_q.vtype;
    assign vill_o  = state_q.vill;

endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
    parameter int VLEN = 128,
    parameter int XLEN = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  instr_valid,
    input logic [31:0]           instr,
    input logic                  cfg_hit,
    input logic [XLEN-1:0]       rd_wdata,
    input logic [$clog2(VLEN):0] vl_o,
    input logic [7:0]            vtype_o,
    input logic                  vill_o
);

    AST_NOHIT_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hit |-> rd_wdata == '0); // R1

    AST_VILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        vill_o |-> (vl_o == '0) && (vtype_o == 8'h00)); // R4

    AST_VL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(vl_o) <= VLEN); // R5

    AST_IMM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cfg_hit && instr[31:30] == 2'b11) |=>
        vill_o || (32'(vl_o) == (($past(instr[19:15]) == 5'd0) ? 32 : 32'($past(instr[19:15]))))); // R8 R9

    AST_RD_IS_VL: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && cfg_hit) |=> 32'(vl_o) == 32'($past(rd_wdata))); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && cfg_hit) |=> $stable(vl_o) && $stable(vtype_o) && $stable(vill_o)); // R11

endmodule

bind vcfg_unit vcfg_unit_chk #(.VLEN(VLEN), .XLEN(XLEN)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .cfg_hit     (cfg_hit),
    .rd_wdata    (rd_wdata),
    .vl_o        (vl_o),
    .vtype_o     (vtype_o),
    .vill_o      (vill_o)
);

// File: tb/vcfg_unit_tb_top.sv
module vcfg_unit_tb_top;

    localparam int VLEN = 128;
    localparam int ELEN = 64;
    localparam int XLEN = 32;
    localparam int VLW  = $clog2(VLEN) + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            instr_valid = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs1_val = '0;
    logic [XLEN-1:0] rs2_val = '0;
    logic            cfg_hit;
    logic [XLEN-1:0] rd_wdata;
    logic [VLW-1:0]  vl_o;
    logic [7:0]      vtype_o;
    logic            vill_o;

    int checks = 0;
    int errors = 0;
    int m_vl   = 0;
    int m_vt   = 0;
    bit m_ill  = 1'b1;

    always #10 clk = ~clk;

    vcfg_unit #(.VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .cfg_hit(cfg_hit), .rd_wdata(rd_wdata),
        .vl_o(vl_o), .vtype_o(vtype_o), .vill_o(vill_o)
    );

    function automatic logic [31:0] enc_ravl(input int rd, input int rs1, input int vt);
        return {1'b0, 11'(vt), 5'(rs1), 3'b111, 5'(rd), 7'b1010111};
    endfunction

    function automatic logic [31:0] enc_iavl(input int rd, input int imm, input int vt);
        return {2'b11, 10'(vt), 5'(imm), 3'b111, 5'(rd), 7'b1010111};
    endfunction

    function automatic logic [31:0] enc_rvt(input int rd, input int rs1, input int rs2);
        return {7'b1000000, 5'(rs2), 5'(rs1), 3'b111, 5'(rd), 7'b1010111};
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] ins, input logic [31:0] r1, input logic [31:0] r2,
                         output bit hit, output int nvl, output int nvt, output bit nill);
        longint vt, avl, vmax;
        int lmc, swc, sew, lm8;
        bit bad;
        hit = (ins[6:0] == 7'b1010111) && (ins[14:12] == 3'b111) &&
              (!ins[31] || ins[31:30] == 2'b11 || ins[31:25] == 7'b1000000);
        if (!ins[31])     vt = longint'(ins[30:20]);
        else if (ins[30]) vt = longint'(ins[29:20]);
        else              vt = longint'({32'd0, r2});
        lmc  = int'(vt & 7);
        swc  = int'((vt >> 3) & 7);
        sew  = 8 << swc;
        lm8  = (lmc < 4) ? (8 << lmc) : (8 >> (8 - lmc));
        bad  = (lmc == 4) || (swc > 3) || (sew > ELEN) || ((vt >> 8) != 0);
        vmax = bad ? 0 : (longint'(VLEN) * lm8) / (8 * sew);
        if (vmax == 0) bad = 1'b1;
        if (ins[31:30] == 2'b11) begin
            avl = (ins[19:15] == 0) ? 32 : longint'(ins[19:15]);
            if (avl > vmax) bad = 1'b1;
        end else begin
            if (ins[19:15] != 0)     avl = longint'({32'd0, r1});
            else if (ins[11:7] != 0) avl = 64'd1 << 40;
            else                     avl = m_vl;
            if (avl > vmax) avl = vmax;
        end
        nvl  = bad ? 0 : int'(avl);
        nvt  = bad ? 0 : int'(vt & 255);
        nill = bad;
    endtask

    task automatic step(input string req, input bit v, input logic [31:0] ins,
                        input logic [31:0] r1, input logic [31:0] r2);
        bit hit, nill;
        int nvl, nvt;
        @(negedge clk);
        instr_valid = v; instr = ins; rs1_val = r1; rs2_val = r2;
        #2;
        model(ins, r1, r2, hit, nvl, nvt, nill);
        check(req, "cfg_hit", cfg_hit, hit);
        check(req, "rd_wdata", rd_wdata, (v && hit) ? nvl : 0);
        if (v && hit) begin
            m_vl = nvl; m_vt = nvt; m_ill = nill;
        end
        @(posedge clk);
        #2;
        check(req, "vl", vl_o, m_vl);
        check(req, "vtype", vtype_o, m_vt);
        check(req, "vill", vill_o, m_ill);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11", "reset vl", vl_o, 0);
        check("R11", "reset vtype", vtype_o, 0);
        check("R11", "reset vill", vill_o, 1);
        rst_n = 1'b1;

        // R5 R2: SEW32 LMUL1 (VLMAX 4), ta/ma set
        step("R5", 1, enc_ravl(1, 5, 'hD0), 3, 0);
        step("R5", 1, enc_ravl(1, 5, 'h10), 4, 0);
        step("R5", 1, enc_ravl(1, 5, 'h10), 5, 0);
        step("R2", 1, enc_ravl(1, 5, 'h03), 100, 0);
        step("R5", 1, enc_ravl(1, 5, 'h03), 1000, 0);
        step("R5", 1, enc_ravl(1, 5, 'h07), 20, 0);
        step("R2", 1, enc_ravl(1, 5, 'h0E), 1, 0);
        step("R2", 1, enc_ravl(1, 5, 'h19), 9, 0);
        // R3 R4: illegal types
        step("R3", 1, enc_ravl(1, 5, 'h1D), 3, 0);
        step("R4", 1, enc_ravl(1, 5, 'h04), 3, 0);
        step("R3", 1, enc_ravl(1, 5, 'h20), 3, 0);
        step("R3", 1, enc_ravl(1, 5, 'h100), 3, 0);
        // R6 / R7
        step("R6", 1, enc_ravl(3, 0, 'h01), 0, 0);
        step("R5", 1, enc_ravl(1, 5, 'h10), 3, 0);
        step("R7", 1, enc_ravl(0, 0, 'h17), 99, 0);
        step("R7", 1, enc_ravl(0, 0, 'h10), 99, 0);
        // register-type form
        step("R1", 1, enc_rvt(2, 6, 7), 50, 'h0B);
        step("R3", 1, enc_rvt(2, 6, 7), 50, 32'h8000_0010);
        step("R6", 1, enc_rvt(2, 0, 7), 0, 'hC8);
        // immediate form
        step("R8", 1, enc_iavl(1, 0, 'h01), 0, 0);
        step("R8", 1, enc_iavl(1, 4, 'h10), 0, 0);
        step("R9", 1, enc_iavl(1, 5, 'h10), 0, 0);
        step("R8", 1, enc_iavl(1, 16, 'hC0), 0, 0);
        step("R9", 1, enc_iavl(1, 31, 'h00), 0, 0);
        step("R9", 1, enc_iavl(1, 0, 'h00), 0, 0);
        step("R3", 1, enc_iavl(1, 2, 'h200), 0, 0);
        // R1 / R11: non-matching words and idle cycles leave state
        step("R10", 1, enc_ravl(4, 5, 'h08), 6, 0);
        step("R1", 1, enc_ravl(4, 5, 'h10) & ~32'h0000_7000, 2, 0);
        step("R1", 1, (enc_rvt(4, 5, 0) | 32'h0200_0000), 2, 'h10);
        step("R1", 1, enc_ravl(4, 5, 'h10) ^ 32'h0000_0004, 2, 0);
        step("R11", 0, enc_ravl(4, 5, 'h10), 2, 0);
        step("R11", 0, enc_iavl(4, 3, 'h00), 0, 0);
        step("R10", 1, enc_ravl(4, 5, 'h00), 17, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule